// File: doc/BRIEF.md
# Warp Issue Scheduler

This block keeps a pool of resident warps, each a group of 32 threads, and on every clock picks at most one warp that can run and issues that warp's next instruction. The output is an issue strobe, a 32-bit lane-enable word, the chosen warp number and that warp's program counter. One issue drives all 32 lanes of the chosen warp.

A warp that waits on memory or on a register dependency is flagged stalled by a per-warp stall input and is passed over. The scheduler hides the stall by issuing another ready warp on the following clock edge, so no cycle is lost. A wake input clears the flag. Warps enter the pool through a per-warp allocate mask, or a whole 256-thread block at once (eight warps), and leave through a retire mask. Each warp carries its own program counter, which moves forward by one on every issue. Fetch, decode, the lanes and memory are outside the block.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one warp issues per clock. While `iss_vld` is 1, `iss_lanes` is all ones (32 lanes). While `iss_vld` is 0, `iss_lanes` is zero.
- R2: A warp may issue only if it is valid and not stalled. A bit of `stall_mask` set in a cycle keeps that warp out of the pick made at the end of that same cycle. The stall flag then stays set until the warp is woken.
- R3: When the last-issued warp stalls and another warp can still run, `iss_vld` stays 1 on the next edge. There is no idle cycle.
- R4: A bit of `wake_mask` clears that warp's stall flag. The warp may issue from the edge after the next one, and the edge that captures the wake still sees it stalled. If stall and wake arrive for the same warp in the same cycle, the stall wins.
- R5: The pick is round-robin. The search starts one past the last issued warp number and wraps from NUM_WARPS-1 to 0. After reset the search starts at warp 0.
- R6: When no warp can run, `iss_vld` is 0 and the round-robin position does not move.
- R7: `iss_pc` shows the chosen warp's program counter before the issue, and that counter then goes up by one. Allocating a warp resets its counter to 0.
- R8: A bit of `alloc_mask` makes that warp valid from the next edge on. A bit of `retire_mask` makes it invalid, and it also keeps the warp out of the pick in that same cycle. If both arrive for one warp in the same cycle, retire wins.
- R9: When `blk_alloc` is 1, the eight warps `blk_sel*8` to `blk_sel*8+7` are allocated. Eight is a 256-thread block divided by 32 lanes.
- R10: The pool holds up to 64 warps, numbered 0 to 63 on the 6-bit `iss_wid`. All of them take part in the rotation.
- R11: After reset, `iss_vld` is 0, `iss_wid` is 0, `iss_pc` is 0, `iss_lanes` is 0, and no warp is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_mask | input | 64 | Per-warp allocate request |
| blk_alloc | input | 1 | Allocate one whole 8-warp block |
| blk_sel | input | 3 | Block number for `blk_alloc` |
| retire_mask | input | 64 | Per-warp retire request |
| stall_mask | input | 64 | Per-warp stall event |
| wake_mask | input | 64 | Per-warp wake event |
| iss_vld | output | 1 | An instruction is issued this cycle |
| iss_lanes | output | 32 | Lane enables of the issued instruction |
| iss_wid | output | 6 | Number of the issued warp |
| iss_pc | output | 16 | Program counter of the issued instruction |

## Verification
The assertions assume that each mask input is stable around the rising edge and is sampled once per cycle. They also assume `blk_sel` is in range whenever `blk_alloc` is 1. They treat stall and wake as one-cycle events, not as levels. The bench changes every input only on the falling edge and keeps each event bit set for one cycle. It uses only the block numbers that exist, and it puts reset between phases, so every property starts from a known pool state.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
   // Round-robin search implementation choice.
   typedef enum logic {
      PICK_SCAN   = 1'b0,  // walk the pool from one past the pointer
      PICK_DOUBLE = 1'b1   // rotate a doubled vector, then priority-pick
   } pick_kind_e;

   function automatic int unsigned wrap_add(int unsigned base, int unsigned off,
                                            int unsigned n);
      int unsigned s;
      s = base + off;
      while (s >= n) s -= n;
      return s;
   endfunction
endpackage

// File: rtl/warp_state.sv
module warp_state #(
   parameter int unsigned NUM_WARPS = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] alloc,
   input  logic [NUM_WARPS-1:0] retire,
   input  logic [NUM_WARPS-1:0] stall,
   input  logic [NUM_WARPS-1:0] wake,
   output logic [NUM_WARPS-1:0] elig
);
   logic [NUM_WARPS-1:0] valid_q;
   logic [NUM_WARPS-1:0] stalled_q;

   for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g]   <= 1'b0;
            stalled_q[g] <= 1'b0;
         end else begin
            if (retire[g])     valid_q[g] <= 1'b0;
            else if (alloc[g]) valid_q[g] <= 1'b1;
            if (stall[g])                 stalled_q[g] <= 1'b1;
            else if (wake[g] || alloc[g]) stalled_q[g] <= 1'b0;
         end
      end

      // Same-cycle stall or retire removes the warp from this edge's pick.
      assign elig[g] = valid_q[g] & ~stalled_q[g] & ~stall[g] & ~retire[g];

      p_wake_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wake[g] && !stall[g]) |=> !stalled_q[g]);
      p_stall_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         stall[g] |=> stalled_q[g]);
      p_retire_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
         retire[g] |=> !valid_q[g]);
      p_alloc_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (alloc[g] && !retire[g]) |=> valid_q[g]);
   end
endmodule

// File: rtl/warp_pick.sv
module warp_pick
   import warp_sched_pkg::*;
#(
   parameter int unsigned NUM_WARPS = 64,
   parameter pick_kind_e  KIND      = PICK_SCAN,
   localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] elig,
   input  logic [WID_W-1:0]     last,
   output logic                 found,
   output logic [WID_W-1:0]     sel
);
   if (KIND == PICK_SCAN) begin : g_scan
      always_comb begin
         int unsigned idx;
         found = 1'b0;
         sel   = '0;
         for (int unsigned k = 1; k <= NUM_WARPS; k++) begin
            idx = wrap_add(int'(last), k, NUM_WARPS);
            if (!found && elig[idx]) begin
               found = 1'b1;
               sel   = WID_W'(idx);
            end
         end
      end
   end else begin : g_double
      logic [2*NUM_WARPS-1:0] dbl;
      logic [2*NUM_WARPS-1:0] rot;
      always_comb begin
         dbl   = {elig, elig};
         rot   = dbl >> (int'(last) + 1);
         found = 1'b0;
         sel   = '0;
         for (int unsigned o = 0; o < NUM_WARPS; o++) begin
            if (!found && rot[o]) begin
               found = 1'b1;
               sel   = WID_W'(wrap_add(int'(last) + 1, o, NUM_WARPS));
            end
         end
      end
   end

   logic [WID_W-1:0] nxt;
   assign nxt = (int'(last) == NUM_WARPS - 1) ? '0 : last + 1'b1;

   p_pick_is_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> elig[sel]);
   p_rr_next_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      elig[nxt] |-> (found && sel == nxt));
endmodule

// File: rtl/warp_pc_file.sv
module warp_pc_file #(
   parameter int unsigned NUM_WARPS = 64,
   parameter int unsigned PC_W      = 16,
   localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] clr,
   input  logic                 inc_en,
   input  logic [WID_W-1:0]     inc_id,
   output logic [PC_W-1:0]      rd_pc
);
   logic [PC_W-1:0] pc_q [NUM_WARPS];

   for (genvar g = 0; g < NUM_WARPS; g++) begin : g_pc
      logic bump;
      assign bump = inc_en && (int'(inc_id) == g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pc_q[g] <= '0;
         else if (clr[g]) pc_q[g] <= '0;
         else if (bump)   pc_q[g] <= pc_q[g] + 1'b1;
      end

      p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (bump && !clr[g]) |=> pc_q[g] == $past(pc_q[g]) + 1'b1);
      p_pc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
         clr[g] |=> pc_q[g] == '0);
   end

   assign rd_pc = pc_q[inc_id];
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import warp_sched_pkg::*;
#(
   parameter int unsigned NUM_WARPS     = 64,
   parameter int unsigned LANES         = 32,
   parameter int unsigned BLOCK_THREADS = 256,
   parameter int unsigned PC_W          = 16,
   parameter pick_kind_e  PICK          = PICK_SCAN,
   localparam int unsigned WID_W        = $clog2(NUM_WARPS),
   localparam int unsigned WPB          = BLOCK_THREADS / LANES,
   localparam int unsigned NUM_BLKS     = NUM_WARPS / WPB,
   localparam int unsigned BLK_W        = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] alloc_mask,
   input  logic                 blk_alloc,
   input  logic [BLK_W-1:0]     blk_sel,
   input  logic [NUM_WARPS-1:0] retire_mask,
   input  logic [NUM_WARPS-1:0] stall_mask,
   input  logic [NUM_WARPS-1:0] wake_mask,
   output logic                 iss_vld,
   output logic [LANES-1:0]     iss_lanes,
   output logic [WID_W-1:0]     iss_wid,
   output logic [PC_W-1:0]      iss_pc
);
   initial begin
      a_pool_cap: assert (NUM_WARPS >= 2 && NUM_WARPS <= 64)
         else $error("pool size out of range");
      a_block_fit: assert (WPB >= 1 && BLOCK_THREADS % LANES == 0 &&
                           NUM_WARPS % WPB == 0)
         else $error("block does not tile the pool");
   end

   // Block allocation expands to a run of WPB warps.
   logic [NUM_WARPS-1:0] blk_mask;
   for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
      assign blk_mask[b*WPB +: WPB] =
         (blk_alloc && int'(blk_sel) == b) ? {WPB{1'b1}} : '0;
   end

   logic [NUM_WARPS-1:0] alloc_all;
   logic [NUM_WARPS-1:0] elig;
   assign alloc_all = alloc_mask | blk_mask;

   warp_state #(.NUM_WARPS(NUM_WARPS)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc  (alloc_all),
      .retire (retire_mask),
      .stall  (stall_mask),
      .wake   (wake_mask),
      .elig   (elig)
   );

   logic [WID_W-1:0] last_q;
   logic             found;
   logic [WID_W-1:0] sel;

   warp_pick #(.NUM_WARPS(NUM_WARPS), .KIND(PICK)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .elig  (elig),
      .last  (last_q),
      .found (found),
      .sel   (sel)
   );

   logic [PC_W-1:0] cur_pc;

   warp_pc_file #(.NUM_WARPS(NUM_WARPS), .PC_W(PC_W)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (alloc_all & ~retire_mask),
      .inc_en (found),
      .inc_id (sel),
      .rd_pc  (cur_pc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= WID_W'(NUM_WARPS - 1);
         iss_vld <= 1'b0;
         iss_wid <= '0;
         iss_pc  <= '0;
      end else begin
         iss_vld <= found;
         if (found) begin
            last_q  <= sel;
            iss_wid <= sel;
            iss_pc  <= cur_pc;
         end
      end
   end

   assign iss_lanes = {LANES{iss_vld}};

   p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |=> iss_vld);
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|elig) |=> (!iss_vld && $stable(last_q)));
   p_issue_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld |-> last_q == iss_wid);
endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
   localparam int N = 64;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  alloc_mask, retire_mask, stall_mask, wake_mask;
   logic          blk_alloc;
   logic [2:0]    blk_sel;
   logic          iss_vld;
   logic [31:0]   iss_lanes;
   logic [5:0]    iss_wid;
   logic [15:0]   iss_pc;

   always #5 clk = ~clk;

   warp_issue_sched dut (
      .clk(clk), .rst_n(rst_n), .alloc_mask(alloc_mask), .blk_alloc(blk_alloc),
      .blk_sel(blk_sel), .retire_mask(retire_mask), .stall_mask(stall_mask),
      .wake_mask(wake_mask), .iss_vld(iss_vld), .iss_lanes(iss_lanes),
      .iss_wid(iss_wid), .iss_pc(iss_pc)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   typedef struct packed {
      logic [7:0]  al, st, wk, rt;
      logic        v;
      logic [5:0]  w;
      logic [15:0] pc;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{8'h0F, 8'h00, 8'h00, 8'h00, 1'b0, 6'd0, 16'd0}, // 0  R8 alloc not yet visible
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd0, 16'd0}, // 1  R5 starts at 0
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd1, 16'd0}, // 2  R5
      '{8'h00, 8'h04, 8'h00, 8'h00, 1'b1, 6'd3, 16'd0}, // 3  R2 same-cycle stall skipped
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd0, 16'd1}, // 4  R7 pc advanced
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd1, 16'd1}, // 5  R2 stall persists
      '{8'h00, 8'h00, 8'h04, 8'h00, 1'b1, 6'd3, 16'd1}, // 6  R4 wake not yet effective
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd0, 16'd2}, // 7  R5
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd1, 16'd2}, // 8  R5
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd2, 16'd0}, // 9  R4 woken warp issues
      '{8'h00, 8'h0F, 8'h00, 8'h00, 1'b0, 6'd0, 16'd0}, // 10 R6 none eligible
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 6'd0, 16'd0}, // 11 R6
      '{8'h00, 8'h00, 8'h09, 8'h00, 1'b0, 6'd0, 16'd0}, // 12 R4 wake edge still idle
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd3, 16'd2}, // 13 R6 pointer held at 2
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd0, 16'd3}, // 14 R5 wrap
      '{8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 6'd3, 16'd3}, // 15 R8 retire masks pick
      '{8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 6'd3, 16'd4}, // 16 R8 re-alloc
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd0, 16'd0}, // 17 R7 pc reset by alloc
      '{8'h80, 8'h08, 8'h00, 8'h00, 1'b1, 6'd0, 16'd1}, // 18 R3 no gap on stall
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd7, 16'd0}, // 19 R5
      '{8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 6'd0, 16'd2}  // 20 R10 wrap past 63
   };

   function automatic string row_req(int i);
      case (i)
         0, 15, 16: return "R8";
         3, 5:      return "R2";
         6, 9, 12:  return "R4";
         10, 11, 13: return "R6";
         4, 17:     return "R7";
         18:        return "R3";
         20:        return "R10";
         default:   return "R5";
      endcase
   endfunction

   task automatic clear_in();
      alloc_mask = '0; retire_mask = '0; stall_mask = '0; wake_mask = '0;
      blk_alloc = 1'b0; blk_sel = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      clear_in();
      repeat (2) @(posedge clk);
      #1;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0;
      clear_in();
      repeat (3) @(posedge clk);
      #1;
      chk("R11 vld", iss_vld, 0);
      chk("R11 wid", iss_wid, 0);
      chk("R11 pc", iss_pc, 0);
      chk("R11 lanes", iss_lanes, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R11 empty pool", iss_vld, 0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         alloc_mask  = N'(VECS[i].al);
         stall_mask  = N'(VECS[i].st);
         wake_mask   = N'(VECS[i].wk);
         retire_mask = N'(VECS[i].rt);
         @(posedge clk);
         #1;
         chk({row_req(i), " vld"}, iss_vld, VECS[i].v);
         chk("R1 lanes", iss_lanes, VECS[i].v ? 32'hFFFF_FFFF : 32'h0);
         if (VECS[i].v) begin
            chk({row_req(i), " wid"}, iss_wid, VECS[i].w);
            chk({row_req(i), " pc"}, iss_pc, VECS[i].pc);
         end
      end

      // R10: full 64-warp pool rotates through every number and wraps.
      do_reset();
      alloc_mask = '1;
      @(negedge clk);
      clear_in();
      for (int i = 0; i <= N; i++) begin
         @(posedge clk);
         #1;
         chk("R10 vld", iss_vld, 1);
         chk("R10 wid", iss_wid, i % N);
         chk("R10 pc", iss_pc, i / N);
      end

      // R9: block 2 allocates warps 16..23.
      do_reset();
      blk_alloc = 1'b1;
      blk_sel   = 3'd2;
      @(negedge clk);
      clear_in();
      for (int i = 0; i < 9; i++) begin
         @(posedge clk);
         #1;
         chk("R9 vld", iss_vld, 1);
         chk("R9 wid", iss_wid, 16 + (i % 8));
         chk("R9 pc", iss_pc, i / 8);
      end

      // R4: stall and wake together, stall wins; pool goes idle (R6).
      @(negedge clk);
      stall_mask = N'(64'h00FF_0000);
      wake_mask  = N'(64'h00FF_0000);
      @(posedge clk);
      #1;
      chk("R4 same-cycle stall", iss_vld, 0);
      @(negedge clk);
      clear_in();
      @(posedge clk);
      #1;
      chk("R4 stall held", iss_vld, 0);
      chk("R1 idle lanes", iss_lanes, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule